// File: doc/BRIEF.md
# Transmit Clock Inactivity Power-Down Controller

This block decides, for each lane of a multi-lane line interface, whether the lane's transmitter and receiver should be powered down. Each transmitter has its own data clock. The block watches that clock from the master clock domain. When a transmit clock stays low for more than a set number of master clock cycles, the transmitter is taken as idle and is powered down. The next rising edge seen on that clock wakes the transmitter again.

A host-mode input selects who else may ask for power-down. In host mode, a per-lane transmit request bit and a per-lane receive request bit can each force power-down. In hardware mode these request bits are ignored. Two more inputs describe the master clock when it is not toggling: one says the clock has stopped, and the other gives the level it stopped at. A stopped-low master clock powers down every receiver. The receive path is combinational, so it keeps working while the master clock is absent.

Top module: `lane_pwrdn_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with every transmit clock high in hardware mode, all bits of `tx_pd_o` are 0.
- R2: Each transmit clock passes through a two-flop synchroniser in the master clock domain. If transmit clock bit i goes low between two master clock edges and stays low, `tx_pd_o[i]` becomes 1 at the 67th master rising edge that follows, and is still 0 after the 66th.
- R3: After a powered-down transmit clock rises and stays high, `tx_pd_o[i]` is still 1 after the 2nd master rising edge and is 0 after the 3rd.
- R4: The low-time counter saturates. A transmit clock held low for hundreds of master cycles keeps `tx_pd_o[i]` at 1 without a break.
- R5: Lanes are independent. A clock going idle on one lane changes only that lane's `tx_pd_o` bit.
- R6: In host mode (`host_mode_i`=1), `tx_pd_o[i]` equals the idle power-down of lane i ORed with `tx_pd_req_i[i]`, in the same cycle.
- R7: In hardware mode (`host_mode_i`=0), `tx_pd_req_i` and `rx_pd_req_i` have no effect. `tx_pd_o` shows only clock inactivity, and `rx_pd_o` is 0 unless the master clock is stopped low.
- R8: In host mode, when the master clock is not stopped low, `rx_pd_o` equals `rx_pd_req_i`.
- R9: When `mclk_stopped_i`=1 and `mclk_level_hi_i`=0, `rx_pd_o` is all ones in either mode. When `mclk_level_hi_i`=1, a stopped clock does not power down the receivers.
- R10: A transmit clock that toggles with a period of 4 master cycles never causes power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_mode_i | input | 1 | 1 = request bits are honoured, 0 = hardware mode |
| mclk_stopped_i | input | 1 | Master clock is not toggling |
| mclk_level_hi_i | input | 1 | Static level of the stopped master clock is high |
| tclk_i | input | LANES | Per-lane transmit data clocks (asynchronous) |
| tx_pd_req_i | input | LANES | Per-lane transmit power-down requests |
| rx_pd_req_i | input | LANES | Per-lane receive power-down requests |
| tx_pd_o | output | LANES | Per-lane transmitter power-down |
| rx_pd_o | output | LANES | Per-lane receiver power-down |

## Verification
The idle decision passes through two synchroniser flops and then the counter register. A low level driven between edges therefore raises `tx_pd_o` at the 67th master edge, and a rising clock clears it at the 3rd. The bench changes inputs only on falling edges and counts falling edges before it samples. It samples one edge early and exactly on time, so an off-by-one in either direction is caught. The request-bit and receive paths are combinational, so they are swept exhaustively and sampled a short delay after each drive, within the same cycle.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int unsigned DEF_LANES       = 8;
  localparam int unsigned DEF_IDLE_LIMIT  = 64;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // counter must reach LIMIT+1 without wrapping
  function automatic int unsigned idle_cnt_width(input int unsigned limit);
    return $clog2(limit + 2);
  endfunction
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shr_q;
  logic [STAGES-1:0] shr_d;

  always_comb begin
    shr_d = {shr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shr_q <= '0;
    else         shr_q <= shr_d;
  end

  assign srst_n = shr_q[STAGES-1];
endmodule

// File: rtl/tclk_idle_mon.sv
module tclk_idle_mon #(
  parameter int unsigned IDLE_LIMIT  = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic tclk_i,
  output logic idle_o
);
  localparam int unsigned CW  = pwrdn_pkg::idle_cnt_width(IDLE_LIMIT);
  localparam logic [CW-1:0] SAT = CW'(IDLE_LIMIT + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   tclk_s;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   cnt_en;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], tclk_i};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign tclk_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_en = tclk_s || (cnt_q != SAT);
    cnt_d  = tclk_s ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle_o = (cnt_q == SAT);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= SAT);

  // R2
  idle_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(idle_o) |-> !$past(tclk_s));

  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (idle_o && tclk_s) |=> !idle_o);
endmodule

// File: rtl/rx_pwrdn_sel.sv
module rx_pwrdn_sel #(
  parameter int unsigned LANES = 8
) (
  input  logic             host_mode_i,
  input  logic             mclk_stopped_i,
  input  logic             mclk_level_hi_i,
  input  logic [LANES-1:0] rx_req_i,
  output logic [LANES-1:0] rx_pd_o
);
  logic all_off;

  always_comb begin
    all_off = mclk_stopped_i && !mclk_level_hi_i;
    rx_pd_o = all_off ? '1 : ({LANES{host_mode_i}} & rx_req_i);
  end

  // R7
  always_comb begin
    if (!host_mode_i && !all_off) begin
      rx_hw_quiet_chk: assert (rx_pd_o == '0);
    end
  end
endmodule

// File: rtl/lane_pwrdn_ctrl.sv
module lane_pwrdn_ctrl #(
  parameter int unsigned LANES       = pwrdn_pkg::DEF_LANES,
  parameter int unsigned IDLE_LIMIT  = pwrdn_pkg::DEF_IDLE_LIMIT,
  parameter int unsigned SYNC_STAGES = pwrdn_pkg::DEF_SYNC_STAGES
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             host_mode_i,
  input  logic             mclk_stopped_i,
  input  logic             mclk_level_hi_i,
  input  logic [LANES-1:0] tclk_i,
  input  logic [LANES-1:0] tx_pd_req_i,
  input  logic [LANES-1:0] rx_pd_req_i,
  output logic [LANES-1:0] tx_pd_o,
  output logic [LANES-1:0] rx_pd_o
);
  logic             srst_n;
  logic [LANES-1:0] idle_vec;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (mclk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tclk_idle_mon #(
      .IDLE_LIMIT  (IDLE_LIMIT),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_mon (
      .clk    (mclk),
      .srst_n (srst_n),
      .tclk_i (tclk_i[g]),
      .idle_o (idle_vec[g])
    );
  end

  always_comb begin
    tx_pd_o = idle_vec | ({LANES{host_mode_i}} & tx_pd_req_i);
  end

  rx_pwrdn_sel #(.LANES(LANES)) u_rx_sel (
    .host_mode_i     (host_mode_i),
    .mclk_stopped_i  (mclk_stopped_i),
    .mclk_level_hi_i (mclk_level_hi_i),
    .rx_req_i        (rx_pd_req_i),
    .rx_pd_o         (rx_pd_o)
  );

  // R6
  host_tx_force_chk: assert property (@(posedge mclk) disable iff (!srst_n)
    host_mode_i |-> ((tx_pd_o & tx_pd_req_i) == tx_pd_req_i));

  // R7
  hw_tx_ignore_chk: assert property (@(posedge mclk) disable iff (!srst_n)
    !host_mode_i |-> (tx_pd_o == idle_vec));
endmodule

// File: tb/lane_pwrdn_ctrl_tb.sv
module lane_pwrdn_ctrl_tb;
  localparam int T = 10;
  localparam int L = 8;

  logic         mclk = 1'b0;
  logic         rst_n;
  logic         host_mode, stopped, level_hi;
  logic [L-1:0] tclk_static, tog_mask, tx_req, rx_req;
  logic         tog = 1'b0;
  logic [L-1:0] tclk, tx_pd, rx_pd;
  int           total = 0, fails = 0;
  bit           done = 0;

  assign tclk = (tog_mask & {L{tog}}) | (~tog_mask & tclk_static);

  always #(T/2) mclk = ~mclk;
  initial forever #(2*T) tog = ~tog;

  lane_pwrdn_ctrl u_dut (
    .mclk(mclk), .rst_n(rst_n), .host_mode_i(host_mode),
    .mclk_stopped_i(stopped), .mclk_level_hi_i(level_hi),
    .tclk_i(tclk), .tx_pd_req_i(tx_req), .rx_pd_req_i(rx_req),
    .tx_pd_o(tx_pd), .rx_pd_o(rx_pd)
  );

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge mclk);
  endtask

  initial begin
    #(T*200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; host_mode = 0; stopped = 0; level_hi = 0;
    tclk_static = '1; tog_mask = '0; tx_req = '0; rx_req = '0;
    step(3);
    chk("R1 in reset", tx_pd, '0);
    rst_n = 1;
    step(4);
    chk("R1 after release", tx_pd, '0);

    // R2 / R5 edge-exact on lane 3
    tclk_static[3] = 1'b0;
    step(66);
    chk("R2 lane3 edge 66", tx_pd, '0);
    step(1);
    chk("R2 lane3 edge 67", tx_pd, 8'h08);
    chk("R5 lane3 only", tx_pd & 8'hF7, '0);
    // R4 saturation
    for (int k = 0; k < 6; k++) begin
      step(50);
      chk("R4 held low", tx_pd, 8'h08);
    end
    // R3 wake
    tclk_static[3] = 1'b1;
    step(2);
    chk("R3 edge 2", tx_pd, 8'h08);
    step(1);
    chk("R3 edge 3", tx_pd, '0);

    // R2 / R3 / R5 sweep of every lane
    for (int c = 0; c < L; c++) begin
      tclk_static = ~(8'h01 << c);
      step(66);
      chk("R2 sweep edge 66", tx_pd, '0);
      step(1);
      chk("R5 sweep edge 67", tx_pd, 8'h01 << c);
      tclk_static = '1;
      step(2);
      chk("R3 sweep edge 2", tx_pd, 8'h01 << c);
      step(1);
      chk("R3 sweep edge 3", tx_pd, '0);
    end

    // R10 toggling clocks
    tog_mask = 8'h5A;
    step(300);
    chk("R10 toggling", tx_pd, '0);
    tog_mask = '0;
    step(4);

    // R6 / R7 exhaustive request sweep with all clocks active
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 256; p++) begin
        host_mode = h[0]; tx_req = p[7:0];
        #1;
        chk(h ? "R6 tx req" : "R7 tx req ignored", tx_pd, h ? p[7:0] : 8'h00);
        step(1);
      end
    end
    // R6 / R7 idle lane combined with requests
    tx_req = 8'h10; host_mode = 0;
    tclk_static = 8'hFB;
    step(67);
    chk("R7 idle plus ignored req", tx_pd, 8'h04);
    host_mode = 1;
    #1;
    chk("R6 idle or req", tx_pd, 8'h14);
    tclk_static = '1; tx_req = '0;
    step(3);
    chk("R3 recover combined", tx_pd, '0);

    // R7 / R8 / R9 exhaustive receive sweep
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 2; s++)
        for (int v = 0; v < 2; v++)
          for (int p = 0; p < 256; p++) begin
            logic [L-1:0] e;
            host_mode = h[0]; stopped = s[0]; level_hi = v[0]; rx_req = p[7:0];
            #1;
            if (s == 1 && v == 0) e = '1;
            else if (h == 1)      e = p[7:0];
            else                  e = '0;
            chk((s == 1 && v == 0) ? "R9 stopped low" :
                (h == 1) ? "R8 rx req" : "R7 rx req ignored", rx_pd, e);
          end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule